// File: doc/BRIEF.md
# Calibrated Converter Register Bank

This block is the digital front end of a serially programmed digital-to-analog converter. A host reaches four registers over a synchronous serial port. The port has an active-low select, a per-bit shift strobe, a serial input and a serial output. The four registers are a control word, a 20-bit sample code, a signed 24-bit offset trim and an unsigned 24-bit gain trim.

The control word sets two things: the order in which field bits travel on the port, and the operating mode. The modes are run, self-trim and standby. From the stored sample, offset and gain, the block forms the trimmed 24-bit code that the analog core converts. In standby, new register values are accepted and can be read back, but the code driven to the core stays frozen. The values stored during standby reach the output in the cycle that run mode is selected again. Self-trim raises a busy flag for a fixed number of cycles and then returns to run mode on its own.

Each frame is one instruction byte followed by one register field. The port only advances on cycles where the shift strobe is high while the select is low. Raising the select abandons the frame.

Top module: `dac_cal_regbank`

## Requirements
- R1: After reset, the sample and offset registers hold zero, the gain register holds 0x800000, the control word holds zero (run mode, most significant bit first), `code` is 0 and `busy` is 0.
- R2: A frame starts with an instruction byte that is always shifted most significant bit first. Bit 7 is 1 for a read and 0 for a write. Bits 1:0 give the address: 0 is the control word (8-bit field), 1 is the sample (20-bit field), 2 is the offset (24-bit field) and 3 is the gain (24-bit field). Bits 6:2 are ignored.
- R3: Control bit 2 sets the field order: 0 means most significant bit first and 1 means least significant bit first. This order applies to the sample, offset and gain fields in both directions, and to reads of the control word. Writes of the control word are always most significant bit first.
- R4: Control bits 1:0 select the mode: 00 is run, 01 is self-trim and 10 is standby. A write carrying 11 leaves the mode unchanged but still updates bit 2.
- R5: Outside standby, `code` equals ((sample·16 + offset) · gain) >> 23. The offset is taken as two's complement, the shift rounds toward minus infinity, and the result is clamped to 0..0xFFFFFF.
- R6: In standby, writes to the sample, offset and gain registers are stored and read back, while `code` keeps its value.
- R7: When a control write selects run mode from standby, `code` reflects the values stored during standby in the same cycle that the write completes.
- R8: After a control write selects self-trim, `busy` is high for exactly CAL_CYCLES cycles, and then the mode reads back as run.
- R9: Raising `selN` in the middle of a frame discards it: no register changes, and the next frame starts from its instruction byte.
- R10: During a read field, `sdo` presents the next field bit before the strobe that consumes it. Outside a read field, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Active-low frame select |
| bitStb | input | 1 | One-cycle strobe, advances the port by one bit |
| sdi | input | 1 | Serial data in, sampled on strobe |
| sdo | output | 1 | Serial data out during read fields |
| busy | output | 1 | High while self-trim runs |
| code | output | 24 | Trimmed converter code |

## Verification
A wrong register value shows up at `code` in the cycle after the write's last strobe. It also shows up in the next readback frame, which catches stored values that standby hides from the output. A mistake in the bit counter or in the order selection makes every later field of the frame wrong, so one read of a known pattern in each order exposes it within a single frame. A mode error shows up through `busy`, through a frozen or unfrozen `code`, or in the control readback at the next frame.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;
  localparam int CODE_W  = 24;
  localparam int DATA_W  = 20;
  localparam int CMD_W   = 8;
  localparam int INSTR_W = 8;
  localparam int ALIGN_SH = CODE_W - DATA_W;
  localparam int GAIN_FRAC = 23;
  localparam logic [CODE_W-1:0] GAIN_UNITY = 24'h800000;

  typedef enum logic [1:0] {
    M_RUN   = 2'b00,
    M_TRIM  = 2'b01,
    M_SLEEP = 2'b10
  } mode_t;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DATA = 2'd1,
    A_OFFS = 2'd2,
    A_GAIN = 2'd3
  } regAddr_t;

  typedef struct packed {
    logic              wrData;
    logic              wrOffs;
    logic              wrGain;
    logic              hold;
    logic [CODE_W-1:0] wrVal;
  } ctrlStb_t;

  typedef struct packed {
    logic [DATA_W-1:0] dataVal;
    logic [CODE_W-1:0] offsVal;
    logic [CODE_W-1:0] gainVal;
  } regView_t;
endpackage

// File: rtl/dac_cal_ctrl.sv
module dac_cal_ctrl
  import dac_cal_pkg::*;
#(
  parameter int CAL_CYCLES = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     selN,
  input  logic     bitStb,
  input  logic     sdi,
  input  regView_t regView,
  output logic     sdo,
  output logic     busy,
  output ctrlStb_t stb
);
  localparam int CNT_W = $clog2(CODE_W + 1);
  localparam int CAL_W = $clog2(CAL_CYCLES + 1);

  typedef enum logic [1:0] {PH_INSTR, PH_FIELD, PH_DONE} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [CODE_W-1:0] shReg;
  logic [CODE_W-1:0] nextSh;
  logic              rdFlag;
  regAddr_t          addrReg;
  logic              lsbFirst;
  mode_t             mode;
  logic [CAL_W-1:0]  calCnt;
  logic [CNT_W-1:0]  fieldW;
  logic              msbEff;
  logic              lastBit;
  logic              stepOk;
  logic              wrCtrl;
  logic [CODE_W-1:0] rdWord;
  logic [CNT_W-1:0]  rdIdx;

  assign stepOk  = bitStb && !selN;
  assign lastBit = (phase == PH_FIELD) && (bitCnt == fieldW - 1'b1);
  assign msbEff  = (addrReg == A_CTRL && !rdFlag) ? 1'b1 : !lsbFirst;

  always_comb begin
    case (addrReg)
      A_CTRL:  fieldW = CNT_W'(CMD_W);
      A_DATA:  fieldW = CNT_W'(DATA_W);
      default: fieldW = CNT_W'(CODE_W);
    endcase
  end

  always_comb begin
    nextSh = shReg;
    if (msbEff) nextSh = {shReg[CODE_W-2:0], sdi};
    else        nextSh[bitCnt] = sdi;
  end

  // write strobes leave the control block in the cycle of the last field bit
  assign wrCtrl     = stepOk && lastBit && !rdFlag && addrReg == A_CTRL;
  assign stb.wrData = stepOk && lastBit && !rdFlag && addrReg == A_DATA;
  assign stb.wrOffs = stepOk && lastBit && !rdFlag && addrReg == A_OFFS;
  assign stb.wrGain = stepOk && lastBit && !rdFlag && addrReg == A_GAIN;
  assign stb.wrVal  = nextSh;
  assign stb.hold   = (mode == M_SLEEP);
  assign busy       = (mode == M_TRIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_INSTR;
      bitCnt  <= '0;
      shReg   <= '0;
      rdFlag  <= 1'b0;
      addrReg <= A_CTRL;
    end else if (selN) begin
      phase  <= PH_INSTR;
      bitCnt <= '0;
      shReg  <= '0;
    end else if (bitStb) begin
      case (phase)
        PH_INSTR: begin
          if (bitCnt == CNT_W'(INSTR_W - 1)) begin
            rdFlag  <= shReg[INSTR_W-2];
            addrReg <= regAddr_t'({shReg[0], sdi});
            shReg   <= '0;
            bitCnt  <= '0;
            phase   <= PH_FIELD;
          end else begin
            shReg  <= {shReg[CODE_W-2:0], sdi};
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_FIELD: begin
          shReg  <= nextSh;
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) phase <= PH_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsbFirst <= 1'b0;
      mode     <= M_RUN;
      calCnt   <= '0;
    end else if (wrCtrl) begin
      lsbFirst <= nextSh[2];
      if (nextSh[1:0] != 2'b11) mode <= mode_t'(nextSh[1:0]);
      calCnt <= CAL_W'(CAL_CYCLES - 1);
    end else if (mode == M_TRIM) begin
      if (calCnt == '0) mode <= M_RUN;
      else              calCnt <= calCnt - 1'b1;
    end
  end

  always_comb begin
    case (addrReg)
      A_CTRL:  rdWord = CODE_W'({lsbFirst, mode});
      A_DATA:  rdWord = CODE_W'(regView.dataVal);
      A_OFFS:  rdWord = regView.offsVal;
      default: rdWord = regView.gainVal;
    endcase
  end

  assign rdIdx = msbEff ? (fieldW - 1'b1 - bitCnt) : bitCnt;
  assign sdo   = (!selN && phase == PH_FIELD && rdFlag) ? rdWord[rdIdx] : 1'b0;

  assert_reserved_mode_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && nextSh[1:0] == 2'b11) |=> (mode == $past(mode)));

  assert_trim_returns_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_TRIM && calCnt == '0 && !wrCtrl) |=> (mode == M_RUN));

  assert_select_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> (phase == PH_INSTR && bitCnt == '0));

  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_FIELD || !rdFlag) |-> !sdo);
endmodule

// File: rtl/dac_cal_dp.sv
module dac_cal_dp
  import dac_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  output regView_t          regView,
  output logic [CODE_W-1:0] code
);
  localparam int SUM_W  = CODE_W + 2;
  localparam int PROD_W = SUM_W + CODE_W + 1;

  logic [DATA_W-1:0] dataReg, heldData, srcData;
  logic [CODE_W-1:0] offsReg, heldOffs, srcOffs;
  logic [CODE_W-1:0] gainReg, heldGain, srcGain;
  logic signed [SUM_W-1:0]  sum;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      offsReg  <= '0;
      gainReg  <= GAIN_UNITY;
      heldData <= '0;
      heldOffs <= '0;
      heldGain <= GAIN_UNITY;
    end else begin
      if (stb.wrData) dataReg <= stb.wrVal[DATA_W-1:0];
      if (stb.wrOffs) offsReg <= stb.wrVal;
      if (stb.wrGain) gainReg <= stb.wrVal;
      if (!stb.hold) begin
        heldData <= dataReg;
        heldOffs <= offsReg;
        heldGain <= gainReg;
      end
    end
  end

  // live registers feed the math unless standby freezes the copies
  assign srcData = stb.hold ? heldData : dataReg;
  assign srcOffs = stb.hold ? heldOffs : offsReg;
  assign srcGain = stb.hold ? heldGain : gainReg;

  assign sum    = $signed({2'b00, srcData, {ALIGN_SH{1'b0}}}) + SUM_W'($signed(srcOffs));
  assign prod   = PROD_W'(sum) * $signed({1'b0, srcGain});
  assign scaled = prod >>> GAIN_FRAC;

  always_comb begin
    if (scaled < 0)                              code = '0;
    else if (scaled > $signed(PROD_W'({CODE_W{1'b1}}))) code = '1;
    else                                         code = scaled[CODE_W-1:0];
  end

  assign regView.dataVal = dataReg;
  assign regView.offsVal = offsReg;
  assign regView.gainVal = gainReg;

  assert_sleep_freezes_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.hold |=> (!stb.hold || $stable(code)));

  assert_sample_stored_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrData |=> (dataReg == $past(stb.wrVal[DATA_W-1:0])));

  assert_unity_passthrough_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.hold && gainReg == GAIN_UNITY && offsReg == '0) |-> (code == {dataReg, {ALIGN_SH{1'b0}}}));
endmodule

// File: rtl/dac_cal_regbank.sv
module dac_cal_regbank
  import dac_cal_pkg::*;
#(
  parameter int CAL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              bitStb,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy,
  output logic [CODE_W-1:0] code
);
  ctrlStb_t stb;
  regView_t regView;

  dac_cal_ctrl #(.CAL_CYCLES(CAL_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .bitStb(bitStb), .sdi(sdi),
    .regView(regView), .sdo(sdo), .busy(busy), .stb(stb)
  );

  dac_cal_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regView(regView), .code(code)
  );
endmodule

// File: tb/dac_cal_regbank_test.sv
module dac_cal_regbank_test;
  localparam int CAL = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic bitStb = 1'b0;
  logic sdi = 1'b0;
  logic sdo, busy;
  logic [23:0] code;

  int tests = 0;
  int fails = 0;

  logic [19:0] mData, hData;
  logic [23:0] mOffs, hOffs, mGain, hGain;
  logic        mLsb;
  logic [1:0]  mMode;

  dac_cal_regbank #(.CAL_CYCLES(CAL)) uut (
    .clk(clk), .rstN(rstN), .selN(selN), .bitStb(bitStb), .sdi(sdi),
    .sdo(sdo), .busy(busy), .code(code)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] expCode(logic [19:0] d, logic [23:0] o, logic [23:0] g);
    longint s, p, r;
    s = longint'({d, 4'b0000}) + longint'($signed(o));
    p = s * longint'({40'd0, g});
    r = p >>> 23;
    if (r < 0) return 24'd0;
    if (r > 64'sh0000_0000_00FF_FFFF) return 24'hFFFFFF;
    return r[23:0];
  endfunction

  function automatic logic [23:0] modelCode();
    if (mMode == 2'b10) return expCode(hData, hOffs, hGain);
    return expCode(mData, mOffs, mGain);
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic b);
    @(negedge clk);
    sdi = b;
    bitStb = 1'b1;
  endtask

  // one full frame; updates the bench model after a write
  task automatic xfer(input logic rd, input logic [1:0] a, input logic [23:0] wv,
                      output logic [23:0] rv);
    int w;
    logic msb;
    logic [7:0] ins;
    w = (a == 2'd0) ? 8 : (a == 2'd1) ? 20 : 24;
    msb = (a == 2'd0 && !rd) ? 1'b1 : !mLsb;
    ins = {rd, 5'($urandom), a};
    rv = '0;
    @(negedge clk);
    selN = 1'b0;
    for (int i = 7; i >= 0; i--) strobe(ins[i]);
    for (int i = 0; i < w; i++) begin
      int k;
      k = msb ? (w - 1 - i) : i;
      @(negedge clk);
      if (rd) rv[k] = sdo;
      sdi = wv[k];
      bitStb = 1'b1;
    end
    @(negedge clk);
    bitStb = 1'b0;
    selN = 1'b1;
    if (!rd) begin
      case (a)
        2'd0: begin
          mLsb = wv[2];
          if (wv[1:0] != 2'b11) mMode = wv[1:0];
        end
        2'd1: mData = wv[19:0];
        2'd2: mOffs = wv;
        default: mGain = wv;
      endcase
      if (mMode != 2'b10) begin
        hData = mData; hOffs = mOffs; hGain = mGain;
      end
    end
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [23:0] exp);
    logic [23:0] rv;
    xfer(1'b1, a, 24'd0, rv);
    check(req, rv, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] v);
    logic [23:0] rv;
    xfer(1'b0, a, v, rv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    mData = '0; mOffs = '0; mGain = 24'h800000; mLsb = 1'b0; mMode = 2'b00;
    hData = '0; hOffs = '0; hGain = 24'h800000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 code", code, 24'd0);
    check("R1 busy", {23'd0, busy}, 24'd0);
    check("R1 sdo idle R10", {23'd0, sdo}, 24'd0);
    readCheck("R1 gain", 2'd3, 24'h800000);
    readCheck("R1 data", 2'd1, 24'd0);
    readCheck("R1 offset", 2'd2, 24'd0);
    readCheck("R1 ctrl", 2'd0, 24'd0);

    // R2 R5 unity path and field widths
    wr(2'd1, 24'hFA5A5);
    check("R5 unity", code, 24'hFA5A50);
    readCheck("R2 data width", 2'd1, 24'h0FA5A5);
    wr(2'd2, 24'hFFFFF0);
    check("R5 negative offset", code, 24'hFA5A40);

    // R5 clamps
    wr(2'd1, 24'd1);
    wr(2'd2, 24'h800000);
    check("R5 clamp low", code, 24'd0);
    wr(2'd1, 24'hFFFFF);
    wr(2'd2, 24'h7FFFFF);
    wr(2'd3, 24'hFFFFFF);
    check("R5 clamp high", code, 24'hFFFFFF);
    wr(2'd3, 24'h400000);
    check("R5 half gain", code, modelCode());

    // R3 order: LSB first for fields, ctrl write still MSB first
    wr(2'd0, 24'h04);
    readCheck("R3 ctrl read lsb order", 2'd0, 24'h04);
    wr(2'd1, 24'h12345);
    readCheck("R3 lsb data", 2'd1, 24'h12345);
    check("R3 lsb code", code, modelCode());
    wr(2'd2, 24'h000123);
    readCheck("R3 lsb offset", 2'd2, 24'h000123);
    wr(2'd0, 24'h00);
    readCheck("R3 msb back", 2'd1, 24'h12345);

    // R4 reserved mode keeps mode, order still applies
    wr(2'd0, 24'h02);
    wr(2'd0, 24'h07);
    readCheck("R4 reserved ignored", 2'd0, 24'h06);
    wr(2'd0, 24'h00);
    readCheck("R4 run", 2'd0, 24'h00);

    // R6 R7 standby
    wr(2'd3, 24'h800000);
    wr(2'd2, 24'd0);
    wr(2'd1, 24'h00100);
    check("R6 before sleep", code, 24'h001000);
    wr(2'd0, 24'h02);
    wr(2'd1, 24'h55555);
    wr(2'd2, 24'h000010);
    check("R6 code frozen", code, 24'h001000);
    readCheck("R6 stored data", 2'd1, 24'h55555);
    readCheck("R6 stored offset", 2'd2, 24'h000010);
    // R7: code must change at the write edge of the run command
    @(negedge clk);
    selN = 1'b0;
    for (int i = 7; i >= 0; i--) strobe(i == 7 ? 1'b0 : 1'b0);
    for (int i = 7; i >= 0; i--) strobe(1'b0);
    @(negedge clk);
    bitStb = 1'b0;
    mMode = 2'b00; hData = mData; hOffs = mOffs; hGain = mGain;
    check("R7 same cycle", code, 24'h555560);
    selN = 1'b1;

    // R8 self-trim busy window
    wr(2'd0, 24'h01);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    mMode = 2'b00;
    check("R8 busy cycles", 24'(n), 24'(CAL));
    readCheck("R8 back to run", 2'd0, 24'h00);

    // R9 abort mid-field
    @(negedge clk);
    selN = 1'b0;
    for (int i = 7; i >= 0; i--) strobe(i == 0 ? 1'b1 : 1'b0);
    for (int i = 0; i < 10; i++) strobe(1'b1);
    @(negedge clk);
    bitStb = 1'b0;
    selN = 1'b1;
    @(negedge clk);
    readCheck("R9 aborted write", 2'd1, 24'h55555);
    check("R9 code kept", code, modelCode());

    // random mix: R2 R3 R5
    for (int it = 0; it < 40; it++) begin
      logic [23:0] d, o, g;
      d = 24'($urandom) & 24'hFFFFF;
      o = 24'($urandom);
      g = 24'($urandom);
      wr(2'd0, {21'd0, 1'($urandom), 2'b00});
      wr(2'd1, d);
      wr(2'd2, o);
      wr(2'd3, g);
      check("R5 random code", code, modelCode());
      if (it % 4 == 0) readCheck("R3 random gain readback", 2'd3, g);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule